// File: doc/BRIEF.md
# Serial Mode S Parity Checker

This block checks the 24-bit parity of a Mode S reply, one bit per cycle, as the bits come out of a pulse-position bit slicer. A controller outside the block tells it which bit opens a message and when the parity field has begun. A bit is taken only in a cycle where the valid strobe is high. The first bit of a message clears the parity register and is then absorbed into it. Each information bit after that passes through a 24-stage feedback shift register made of XOR taps.

While the parity phase is flagged, the register stops dividing and shifts its contents out, most significant bit first. Each bit that leaves the register is compared with the parity bit received in the same cycle. A disagreement sets a sticky mismatch flag. One cycle after the last bit of the message, a done pulse is issued together with a pass or fail verdict. The message is 112 bits long, or 56 bits in short mode. These verdict flags hold until the next message starts.

Top module: `mscrc_checker`

## Requirements
- R1: After synchronous reset, done, msg_ok, msg_err and mismatch are all 0.
- R2: A bit taken with first_bit high starts the division from an all-zero register, so any earlier message, complete or not, has no effect on the next verdict.
- R3: For a long message (short_mode low when the first bit is taken), the parity is the remainder of the 88 information bits, sent first bit first, divided by generator 0x1FFF409 with a zero start. The 24 parity bits carry that remainder MSB first. When all 24 match, msg_ok is 1 and msg_err is 0 from the cycle after the 112th bit is taken.
- R4: With short_mode high when the first bit is taken, the message has 32 information bits and 24 parity bits. The verdict and done appear in the cycle after the 56th bit is taken.
- R5: Any parity bit that differs from the computed bit sets mismatch in the next cycle, and mismatch stays set until the next first bit. The verdict is then msg_err=1, msg_ok=0.
- R6: A corrupted information bit with untouched parity gives msg_err=1.
- R7: Cycles with bit_vld low change nothing: idle gaps of any length between bits leave the verdict unchanged.
- R8: msg_ok and msg_err hold after done until the next first bit is taken, which clears them and mismatch in the following cycle.
- R9: done is high for exactly one cycle per message. Extra bits taken without a new first bit never raise done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Decided message bit |
| bit_vld | input | 1 | bit_in is taken in this cycle |
| first_bit | input | 1 | Qualifies the first bit of a message |
| empty_en | input | 1 | High while parity bits are being received |
| short_mode | input | 1 | Selects 56-bit message, sampled on the first bit |
| done | output | 1 | One-cycle pulse after the final bit |
| msg_ok | output | 1 | All parity bits matched |
| msg_err | output | 1 | At least one bit failed the check |
| mismatch | output | 1 | Sticky parity disagreement flag |

## Verification
The bench flips single parity bits at random positions, including the first and last, and confirms that mismatch rises in the cycle after the bad bit. A design that compared against the wrong end of the register, or that did not hold the flag, would miss some of these positions. Flipped information bits catch a feedback tap that is missing or misplaced. Short and long messages are mixed, with random idle gaps between bits, so a counter that is off by one or that steps on idle cycles shows up as a misplaced done. Stray bits sent after a message ends catch a done that fires a second time. A clean message sent straight after a failed one catches a register that is not cleared.

// File: rtl/mscrc_pkg.sv
package mscrc_pkg;
  localparam int unsigned CRC_W = 24;
  localparam logic [CRC_W:0] MODES_GEN = 25'h1FFF409;
  typedef enum logic {PH_DIVIDE = 1'b0, PH_EMPTY = 1'b1} phase_e;
endpackage

// File: rtl/mscrc_lfsr.sv
module mscrc_lfsr
  import mscrc_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W:0] GEN = MODES_GEN
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic first_bit,
  input  logic empty_en,
  output logic par_miss
);
  logic [W-1:0] crc_q, base, crc_d;
  phase_e ph;

  always_comb begin
    ph   = (empty_en && !first_bit) ? PH_EMPTY : PH_DIVIDE;
    base = first_bit ? '0 : crc_q;
    crc_d = crc_q;
    if (bit_vld) begin
      if (ph == PH_EMPTY)
        crc_d = {base[W-2:0], 1'b0};
      else
        crc_d = {base[W-2:0], 1'b0} ^ ((base[W-1] ^ bit_in) ? GEN[W-1:0] : '0);
    end
    par_miss = bit_vld && (ph == PH_EMPTY) && (crc_q[W-1] != bit_in);
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '0;
    else     crc_q <= crc_d;
  end

  // R7: an idle cycle leaves the register untouched
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(crc_q));
  // R2: the first bit starts from zero, so the register holds the tap pattern or zero
  a_r2_fresh_start: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && first_bit) |=> (crc_q == '0 || crc_q == GEN[W-1:0]));
endmodule

// File: rtl/mscrc_seq.sv
module mscrc_seq #(
  parameter int unsigned LONG_BITS  = 112,
  parameter int unsigned SHORT_BITS = 56,
  localparam int unsigned CW = $clog2(LONG_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic first_bit,
  input  logic short_mode,
  output logic last_bit
);
  logic [CW-1:0] cnt_q, cnt_next, target;
  logic short_q, armed_q, short_eff;

  always_comb begin
    short_eff = first_bit ? short_mode : short_q;
    target    = short_eff ? CW'(SHORT_BITS) : CW'(LONG_BITS);
    cnt_next  = first_bit ? CW'(1) : cnt_q + CW'(1);
    last_bit  = bit_vld && (armed_q || first_bit) && (cnt_next == target);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
      armed_q <= 1'b0;
    end else if (bit_vld) begin
      if (first_bit) begin
        short_q <= short_mode;
        armed_q <= 1'b1;
        cnt_q   <= cnt_next;
      end else if (armed_q) begin
        cnt_q <= cnt_next;
      end
      if (last_bit) armed_q <= 1'b0;
    end
  end

  // R9: a message ends at most once before it is re-armed
  a_r9_single_end: assert property (@(posedge clk) disable iff (rst)
    last_bit |=> !armed_q);
  // R7: the count never moves on an idle cycle
  a_r7_count_idle: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(cnt_q));
endmodule

// File: rtl/mscrc_checker.sv
module mscrc_checker
  import mscrc_pkg::*;
#(
  parameter int unsigned W          = CRC_W,
  parameter logic [W:0]  GEN        = MODES_GEN,
  parameter int unsigned LONG_BITS  = 112,
  parameter int unsigned SHORT_BITS = 56
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic first_bit,
  input  logic empty_en,
  input  logic short_mode,
  output logic done,
  output logic msg_ok,
  output logic msg_err,
  output logic mismatch
);
  logic par_miss, last_bit, start;

  mscrc_lfsr #(.W(W), .GEN(GEN)) u_lfsr (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .first_bit(first_bit), .empty_en(empty_en), .par_miss(par_miss));

  mscrc_seq #(.LONG_BITS(LONG_BITS), .SHORT_BITS(SHORT_BITS)) u_seq (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .first_bit(first_bit),
    .short_mode(short_mode), .last_bit(last_bit));

  assign start = bit_vld && first_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      msg_ok   <= 1'b0;
      msg_err  <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      done <= last_bit;
      if (start) begin
        mismatch <= 1'b0;
        msg_ok   <= 1'b0;
        msg_err  <= 1'b0;
      end else if (par_miss) begin
        mismatch <= 1'b1;
      end
      if (last_bit) begin
        msg_ok  <= !(mismatch || par_miss);
        msg_err <= mismatch || par_miss;
      end
    end
  end

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: verdict agrees with the sticky flag at completion
  a_r5_err_tracks: assert property (@(posedge clk) disable iff (rst)
    done |-> (msg_err == mismatch) && (msg_ok == !mismatch));
  // R5: mismatch stays set until a new message starts
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !start) |=> mismatch);
  // R8: a new message clears verdict and flag
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    start |=> (!mismatch && !msg_ok && !msg_err));
endmodule

// File: tb/mscrc_checker_test.sv
module mscrc_checker_test;
  logic clk = 1'b0;
  logic rst, bit_in, bit_vld, first_bit, empty_en, short_mode;
  logic done, msg_ok, msg_err, mismatch;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mscrc_checker uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .first_bit(first_bit), .empty_en(empty_en), .short_mode(short_mode),
    .done(done), .msg_ok(msg_ok), .msg_err(msg_err), .mismatch(mismatch));

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // long division of info bits (MSB first) augmented with 24 zeros
  function automatic logic [23:0] par_of(input logic [87:0] info, input int n);
    logic [24:0] rem = '0;
    for (int i = n - 1; i >= -24; i--) begin
      rem = {rem[23:0], (i >= 0) ? info[i] : 1'b0};
      if (rem[24]) rem = rem ^ 25'h1FFF409;
    end
    return rem[23:0];
  endfunction

  function automatic logic [111:0] build(input logic [87:0] info, input bit shrt);
    int n = shrt ? 32 : 88;
    logic [111:0] m = '0;
    logic [23:0] p = par_of(info, n);
    for (int i = 0; i < 24; i++) m[i] = p[i];
    for (int i = 0; i < n; i++) m[24 + i] = info[i];
    return m;
  endfunction

  // sends message bits MSB first; flip < 0 means no corruption
  task automatic send(input logic [111:0] m, input bit shrt, input int flip,
                      input bit gaps, input string req);
    int len = shrt ? 56 : 112;
    for (int k = 0; k < len; k++) begin
      int idx = len - 1 - k;
      @(negedge clk);
      bit_vld    = 1'b1;
      first_bit  = (k == 0);
      short_mode = shrt;
      empty_en   = (k >= len - 24);
      bit_in     = m[idx] ^ (idx == flip);
      if (k == len - 1) break;
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        bit_vld = 1'b0; first_bit = 1'b0; bit_in = ~bit_in;
        for (int g = 0; g < int'($urandom % 4); g++) @(negedge clk);
      end
    end
    @(negedge clk);
    bit_vld = 1'b0; first_bit = 1'b0; empty_en = 1'b0;
    chk(done == 1'b1, {req, " done after last bit"}, done, 1);
    chk(msg_ok == (flip < 0) && msg_err == (flip >= 0), {req, " verdict"}, msg_err, flip >= 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  logic [87:0] info;
  logic [111:0] msg;

  initial begin
    void'($urandom(32'd1090));
    rst = 1'b1; bit_in = 0; bit_vld = 0; first_bit = 0; empty_en = 0; short_mode = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({done, msg_ok, msg_err, mismatch} == 4'b0, "R1 reset state", {done, msg_ok, msg_err, mismatch}, 0);

    // directed: all-zero info gives zero parity
    send('0, 1'b0, -1, 1'b0, "R3 zero msg");
    for (int t = 0; t < 6; t++) begin
      info = {$urandom, $urandom, $urandom};
      send(build(info, 1'b0), 1'b0, -1, 1'b0, "R3 long good");
      send(build(info, 1'b1), 1'b1, -1, 1'b0, "R4 short good");
    end
    for (int t = 0; t < 4; t++) begin
      info = {$urandom, $urandom, $urandom};
      send(build(info, t[0]), t[0], -1, 1'b1, "R7 gaps");
    end
    // flipped parity bits, edges first
    for (int t = 0; t < 6; t++) begin
      int f = (t == 0) ? 0 : (t == 1) ? 23 : int'($urandom % 24);
      info = {$urandom, $urandom, $urandom};
      send(build(info, 1'b0), 1'b0, f, 1'b0, "R5 parity flip");
      chk(mismatch == 1'b1, "R5 sticky mismatch", mismatch, 1);
    end
    // mismatch appears the cycle after the bad bit (bit index 23 = first parity bit)
    info = {$urandom, $urandom, $urandom};
    msg = build(info, 1'b1);
    for (int k = 0; k < 34; k++) begin
      @(negedge clk);
      bit_vld = 1; first_bit = (k == 0); short_mode = 1; empty_en = (k >= 32);
      bit_in = msg[55 - k] ^ (k == 32);
    end
    @(negedge clk);
    bit_vld = 0; first_bit = 0;
    chk(mismatch == 1'b1, "R5 mismatch next cycle", mismatch, 1);
    // R2: abandoned message, then a clean one
    send(build(info, 1'b1), 1'b1, -1, 1'b0, "R2 restart clean");
    for (int t = 0; t < 4; t++) begin
      info = {$urandom, $urandom, $urandom};
      send(build(info, t[0]), t[0], 30 + int'($urandom % 20), 1'b0, "R6 info flip");
    end
    // R8 hold and clear, R9 no done on stray bits
    info = {$urandom, $urandom, $urandom};
    send(build(info, 1'b0), 1'b0, -1, 1'b0, "R8 setup");
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      bit_vld = 1; bit_in = $urandom; empty_en = $urandom;
      chk(done == 1'b0, "R9 no done on stray bits", done, 0);
    end
    @(negedge clk);
    bit_vld = 0;
    @(negedge clk);
    chk(msg_ok == 1'b1 && msg_err == 1'b0, "R8 verdict held", msg_ok, 1);
    bit_vld = 1; first_bit = 1; bit_in = 1;
    @(negedge clk);
    bit_vld = 0; first_bit = 0;
    chk({msg_ok, msg_err, mismatch} == 3'b0, "R8 cleared by first bit", {msg_ok, msg_err, mismatch}, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule